// File: doc/BRIEF.md
# Pending Interrupt Dispatch Unit

This block keeps a small set of pending interrupt request bits for a processor core and, each time it receives a dispatch strobe, services exactly one of them. There are seven request sources. Three are controller or mode events: a poll of the local interrupt controller, a startup inter-processor request and a system-management request. The other four deliver vectors: non-maskable, machine-check, external hardware and virtual hardware. Several requests may be pending at once. Only the one with the highest priority is consumed, and the rest wait for later dispatches. This keeps the order of servicing deterministic.

For the serviced source, the block clears the pending bits that the source's rule names, updates two side flags, and chooses the vector to deliver. The side flags are a sticky NMI-blocked flag and a virtual-IRQ control bit. The block also marks whether the event counts as hardware-sourced and fires whatever strobe the source needs. The hardware vector comes from an external controller, which is acknowledged in the dispatch cycle. The virtual vector is taken from a control-block value input. Sources that an enclosing monitor may intercept also emit a strobe with an exit code. Results are registered and appear one cycle after the dispatch.

Top module: `irq_dispatch_unit`

## Requirements
- R1: During and after synchronous reset, `pending` is 0, `nmi_blocked` and `vctl_irq` are 0, and every result output and strobe is 0.
- R2: Each `req_set` bit ORs into the matching pending bit at the next edge. Bit map: 0 poll, 1 startup, 2 system-management, 3 non-maskable, 4 machine-check, 5 hardware, 6 virtual. A set in the same cycle as a clear of that bit wins. Likewise, `vctl_set` wins over a clear of `vctl_irq`.
- R3: One dispatch services only the lowest-numbered pending bit. All other pending bits are kept.
- R4: A dispatch with nothing pending gives `done`=1 and `taken`=0, and it changes neither the pending bits nor the flags.
- R5: Poll: clears bit 0 and pulses `poll_stb`. `vec_valid`=0 and no intercept.
- R6: Startup: clears bit 1 and pulses `sipi_stb`. `vec_valid`=0 and no intercept.
- R7: System-management: pulses `icpt_stb` with `icpt_code`=1, clears bit 2, pulses `smm_stb` and gives no vector.
- R8: Non-maskable: `icpt_code`=2, clears bit 3, delivers vector 2 with `is_hw`=1 and sets `nmi_blocked`. The flag stays set until `nmi_unblock` or reset.
- R9: Machine-check: clears bit 4 and delivers vector 18 with `is_hw`=0 and no intercept.
- R10: Hardware: `icpt_code`=3, clears bits 5 and 6, drives `hw_ack` high during the dispatch cycle, delivers the `hw_vector` sampled in that cycle with `is_hw`=1, and leaves `vctl_irq` unchanged.
- R11: Virtual: `icpt_code`=4, delivers `virt_vector` with `is_hw`=1, clears bit 6 and clears `vctl_irq`.
- R12: The results (`done`, `taken`, vector fields and strobes) appear in the cycle after the dispatch cycle and last one cycle. With no dispatch they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 7 | Pending-bit set pulses, one per source |
| dispatch | input | 1 | Service one pending request this cycle |
| nmi_unblock | input | 1 | Clears the NMI-blocked flag |
| vctl_set | input | 1 | Sets the virtual-IRQ control bit |
| hw_vector | input | 8 | Vector from the external controller |
| virt_vector | input | 8 | Vector from the control block |
| hw_ack | output | 1 | Acknowledge to the external controller in the dispatch cycle |
| done | output | 1 | A dispatch completed last cycle |
| taken | output | 1 | That dispatch serviced a request |
| vec_valid | output | 1 | A vector is delivered |
| vector | output | 8 | Delivered vector number |
| is_hw | output | 1 | Delivered event is hardware-sourced |
| icpt_stb | output | 1 | Intercept check strobe |
| icpt_code | output | 4 | Intercept exit code |
| poll_stb | output | 1 | Local controller poll strobe |
| sipi_stb | output | 1 | Startup handler strobe |
| smm_stb | output | 1 | System-management entry strobe |
| pending | output | 7 | Current pending bits |
| nmi_blocked | output | 1 | Sticky NMI-blocked flag |
| vctl_irq | output | 1 | Virtual-IRQ control bit |

## Verification
The hardest state to reach is a hardware request and a virtual request pending together. There the hardware dispatch must also remove the virtual bit, so a drain of all seven sources ends one dispatch early. The bench loads every bit and dispatches back to back, then checks the pending word after each step. It also drives a new virtual request and `vctl_set` into the very cycle that would clear them, which shows that the set wins.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    localparam int NSRC   = 7;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int VEC_W  = 8;
    localparam int CODE_W = 4;

    typedef enum logic [IDX_W-1:0] {
        SRC_POLL = 3'd0,
        SRC_SIPI = 3'd1,
        SRC_SMM  = 3'd2,
        SRC_NMI  = 3'd3,
        SRC_MCE  = 3'd4,
        SRC_HARD = 3'd5,
        SRC_VIRT = 3'd6
    } src_e;

    localparam logic [VEC_W-1:0]  NMI_VECTOR = VEC_W'(2);
    localparam logic [VEC_W-1:0]  MCE_VECTOR = VEC_W'(18);
    localparam logic [CODE_W-1:0] EXIT_SMM   = CODE_W'(1);
    localparam logic [CODE_W-1:0] EXIT_NMI   = CODE_W'(2);
    localparam logic [CODE_W-1:0] EXIT_HARD  = CODE_W'(3);
    localparam logic [CODE_W-1:0] EXIT_VIRT  = CODE_W'(4);

    typedef struct packed {
        logic              taken;
        logic              vec_valid;
        logic [VEC_W-1:0]  vector;
        logic              is_hw;
        logic              icpt;
        logic [CODE_W-1:0] icpt_code;
        logic              poll;
        logic              sipi;
        logic              smm;
        logic              hw_ack;
        logic [NSRC-1:0]   clr;
        logic              nmi_set;
        logic              vctl_clr;
    } action_t;

    function automatic action_t decode_action(
        input logic             found,
        input src_e             src,
        input logic [VEC_W-1:0] hw_vec,
        input logic [VEC_W-1:0] virt_vec
    );
        action_t a;
        a       = '0;
        a.taken = found;
        if (found) begin
            a.clr[int'(src)] = 1'b1;
            case (src)
                SRC_POLL: a.poll = 1'b1;
                SRC_SIPI: a.sipi = 1'b1;
                SRC_SMM: begin
                    a.icpt      = 1'b1;
                    a.icpt_code = EXIT_SMM;
                    a.smm       = 1'b1;
                end
                SRC_NMI: begin
                    a.icpt      = 1'b1;
                    a.icpt_code = EXIT_NMI;
                    a.nmi_set   = 1'b1;
                    a.vec_valid = 1'b1;
                    a.vector    = NMI_VECTOR;
                    a.is_hw     = 1'b1;
                end
                SRC_MCE: begin
                    a.vec_valid = 1'b1;
                    a.vector    = MCE_VECTOR;
                end
                SRC_HARD: begin
                    a.icpt      = 1'b1;
                    a.icpt_code = EXIT_HARD;
                    a.hw_ack    = 1'b1;
                    a.vec_valid = 1'b1;
                    a.vector    = hw_vec;
                    a.is_hw     = 1'b1;
                    a.clr[int'(SRC_VIRT)] = 1'b1;
                end
                SRC_VIRT: begin
                    a.icpt      = 1'b1;
                    a.icpt_code = EXIT_VIRT;
                    a.vec_valid = 1'b1;
                    a.vector    = virt_vec;
                    a.is_hw     = 1'b1;
                    a.vctl_clr  = 1'b1;
                end
                default: a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/irq_disp_arbiter.sv
module irq_disp_arbiter #(
    parameter int N     = 7,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            assign grant[g]  = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_disp_decode.sv
module irq_disp_decode
    import irq_disp_pkg::*;
(
    input  logic             found,
    input  logic [IDX_W-1:0] idx,
    input  logic [VEC_W-1:0] hw_vec,
    input  logic [VEC_W-1:0] virt_vec,
    output action_t          act
);
    always_comb begin
        act = decode_action(found, src_e'(idx), hw_vec, virt_vec);
    end
endmodule

// File: rtl/irq_disp_state.sv
module irq_disp_state #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         nmi_set,
    input  logic         nmi_clr,
    input  logic         vctl_set,
    input  logic         vctl_clr,
    output logic [N-1:0] pend,
    output logic         nmi_blk,
    output logic         vctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            nmi_blk <= 1'b0;
            vctl    <= 1'b0;
        end else begin
            pend <= (pend & ~clr) | set;
            if (nmi_clr)      nmi_blk <= 1'b0;
            else if (nmi_set) nmi_blk <= 1'b1;
            if (vctl_set)      vctl <= 1'b1;
            else if (vctl_clr) vctl <= 1'b0;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pend == '0) && !nmi_blk && !vctl);

    assert_nmi_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        nmi_blk && !nmi_clr |=> nmi_blk);

    assert_vctl_cleared_R11: assert property (@(posedge clk) disable iff (rst)
        vctl_clr && !vctl_set |=> !vctl);

    assert_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
    import irq_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req_set,
    input  logic              dispatch,
    input  logic              nmi_unblock,
    input  logic              vctl_set,
    input  logic [VEC_W-1:0]  hw_vector,
    input  logic [VEC_W-1:0]  virt_vector,
    output logic              hw_ack,
    output logic              done,
    output logic              taken,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vector,
    output logic              is_hw,
    output logic              icpt_stb,
    output logic [CODE_W-1:0] icpt_code,
    output logic              poll_stb,
    output logic              sipi_stb,
    output logic              smm_stb,
    output logic [NSRC-1:0]   pending,
    output logic              nmi_blocked,
    output logic              vctl_irq
);
    logic             found;
    logic [IDX_W-1:0] idx;
    logic [NSRC-1:0]  grant;
    action_t          act;
    action_t          live;
    action_t          res_q;
    logic             done_q;

    irq_disp_arbiter #(.N(NSRC)) u_arb (
        .req   (pending),
        .found (found),
        .idx   (idx),
        .grant (grant)
    );

    irq_disp_decode u_dec (
        .found    (found),
        .idx      (idx),
        .hw_vec   (hw_vector),
        .virt_vec (virt_vector),
        .act      (act)
    );

    assign live = dispatch ? act : '0;

    irq_disp_state #(.N(NSRC)) u_state (
        .clk      (clk),
        .rst      (rst),
        .set      (req_set),
        .clr      (live.clr),
        .nmi_set  (live.nmi_set),
        .nmi_clr  (nmi_unblock),
        .vctl_set (vctl_set),
        .vctl_clr (live.vctl_clr),
        .pend     (pending),
        .nmi_blk  (nmi_blocked),
        .vctl     (vctl_irq)
    );

    assign hw_ack = live.hw_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            res_q  <= live;
            done_q <= dispatch;
        end
    end

    assign done      = done_q;
    assign taken     = res_q.taken;
    assign vec_valid = res_q.vec_valid;
    assign vector    = res_q.vector;
    assign is_hw     = res_q.is_hw;
    assign icpt_stb  = res_q.icpt;
    assign icpt_code = res_q.icpt_code;
    assign poll_stb  = res_q.poll;
    assign sipi_stb  = res_q.sipi;
    assign smm_stb   = res_q.smm;

    assert_idle_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        dispatch && (pending == '0) && (req_set == '0) && !nmi_unblock && !vctl_set
        |=> done && !taken && (pending == '0) && $stable(nmi_blocked) && $stable(vctl_irq));

    assert_quiet_without_dispatch_R12: assert property (@(posedge clk) disable iff (rst)
        !dispatch |=> !done && !taken && !vec_valid && !icpt_stb
                      && !poll_stb && !sipi_stb && !smm_stb);

    assert_hw_delivery_R10: assert property (@(posedge clk) disable iff (rst)
        hw_ack |=> vec_valid && is_hw && icpt_stb && (icpt_code == EXIT_HARD)
                   && (vector == $past(hw_vector)));

    assert_single_action_R3: assert property (@(posedge clk) disable iff (rst)
        done && taken |-> $countones({poll_stb, sipi_stb, smm_stb, vec_valid}) == 1);

    assert_taken_when_pending_R3: assert property (@(posedge clk) disable iff (rst)
        dispatch && (pending != '0) |=> done && taken);
endmodule

// File: tb/test_irq_dispatch_unit.sv
module test_irq_dispatch_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] req_set = '0;
    logic       dispatch = 1'b0;
    logic       nmi_unblock = 1'b0;
    logic       vctl_set = 1'b0;
    logic [7:0] hw_vector = '0;
    logic [7:0] virt_vector = '0;
    logic       hw_ack, done, taken, vec_valid, is_hw, icpt_stb;
    logic       poll_stb, sipi_stb, smm_stb, nmi_blocked, vctl_irq;
    logic [7:0] vector;
    logic [3:0] icpt_code;
    logic [6:0] pending;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_dispatch_unit i_irq_dispatch_unit (
        .clk(clk), .rst(rst), .req_set(req_set), .dispatch(dispatch),
        .nmi_unblock(nmi_unblock), .vctl_set(vctl_set),
        .hw_vector(hw_vector), .virt_vector(virt_vector),
        .hw_ack(hw_ack), .done(done), .taken(taken), .vec_valid(vec_valid),
        .vector(vector), .is_hw(is_hw), .icpt_stb(icpt_stb), .icpt_code(icpt_code),
        .poll_stb(poll_stb), .sipi_stb(sipi_stb), .smm_stb(smm_stb),
        .pending(pending), .nmi_blocked(nmi_blocked), .vctl_irq(vctl_irq)
    );

    typedef struct packed {
        logic [6:0] pend;
        logic       vctl;
        logic [7:0] hwv;
        logic [7:0] vv;
        logic       e_taken;
        logic       e_vvalid;
        logic [7:0] e_vec;
        logic       e_hw;
        logic       e_icpt;
        logic [3:0] e_code;
        logic [2:0] e_strb;
        logic [6:0] e_pend;
        logic       e_nmi;
        logic       e_vctl;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TBL [NTV] = '{
        '{7'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 4'd0, 3'b000, 7'h00, 1'b0, 1'b0}, // R4
        '{7'h7F, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 4'd0, 3'b100, 7'h7E, 1'b0, 1'b0}, // R5
        '{7'h7E, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 4'd0, 3'b010, 7'h7C, 1'b0, 1'b0}, // R6
        '{7'h7C, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'd0,  1'b0, 1'b1, 4'd1, 3'b001, 7'h78, 1'b0, 1'b0}, // R7
        '{7'h78, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd2,  1'b1, 1'b1, 4'd2, 3'b000, 7'h70, 1'b1, 1'b0}, // R8
        '{7'h70, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'd18, 1'b0, 1'b0, 4'd0, 3'b000, 7'h60, 1'b0, 1'b0}, // R9
        '{7'h60, 1'b1, 8'h31, 8'h77, 1'b1, 1'b1, 8'h31, 1'b1, 1'b1, 4'd3, 3'b000, 7'h00, 1'b0, 1'b1}, // R10
        '{7'h40, 1'b1, 8'h31, 8'h55, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 4'd4, 3'b000, 7'h00, 1'b0, 1'b0}, // R11
        '{7'h41, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 4'd0, 3'b100, 7'h40, 1'b0, 1'b0}, // R3
        '{7'h28, 1'b0, 8'h99, 8'h00, 1'b1, 1'b1, 8'd2,  1'b1, 1'b1, 4'd2, 3'b000, 7'h20, 1'b1, 1'b0}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_set = '0; dispatch = 1'b0; nmi_unblock = 1'b0; vctl_set = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [6:0] p, input logic v);
        req_set  = p;
        vctl_set = v;
        @(negedge clk);
        req_set  = '0;
        vctl_set = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 pending", 32'(pending), 0);
        chk("R1 flags", {30'd0, nmi_blocked, vctl_irq}, 0);
        chk("R1 results", {25'd0, done, taken, vec_valid, icpt_stb, poll_stb, sipi_stb, smm_stb}, 0);
        rst = 1'b0;

        // table walk
        for (int k = 0; k < NTV; k++) begin
            do_reset();
            load(TBL[k].pend, TBL[k].vctl);
            hw_vector   = TBL[k].hwv;
            virt_vector = TBL[k].vv;
            dispatch    = 1'b1;
            #1;
            chk($sformatf("R10 hw_ack row %0d", k), 32'(hw_ack),
                32'(TBL[k].e_code == 4'd3));
            @(negedge clk);
            dispatch = 1'b0;
            chk($sformatf("R12 done row %0d", k), 32'(done), 1);
            chk($sformatf("R3 taken row %0d", k), 32'(taken), 32'(TBL[k].e_taken));
            chk($sformatf("R8 vector row %0d", k), {22'd0, vec_valid, is_hw, vector},
                {22'd0, TBL[k].e_vvalid, TBL[k].e_hw, TBL[k].e_vec});
            chk($sformatf("R7 intercept row %0d", k), {27'd0, icpt_stb, icpt_code},
                {27'd0, TBL[k].e_icpt, TBL[k].e_code});
            chk($sformatf("R5 strobes row %0d", k), {29'd0, poll_stb, sipi_stb, smm_stb},
                {29'd0, TBL[k].e_strb});
            chk($sformatf("R3 pending row %0d", k), 32'(pending), 32'(TBL[k].e_pend));
            chk($sformatf("R11 flags row %0d", k), {30'd0, nmi_blocked, vctl_irq},
                {30'd0, TBL[k].e_nmi, TBL[k].e_vctl});
        end

        // R12: results last one cycle
        @(negedge clk);
        chk("R12 pulse ends", {30'd0, done, vec_valid}, 0);

        // R8: sticky NMI-blocked across an idle dispatch, cleared by unblock
        do_reset();
        load(7'h08, 1'b0);
        dispatch = 1'b1;
        @(negedge clk);
        dispatch = 1'b1;
        @(negedge clk);
        dispatch = 1'b0;
        chk("R4 idle dispatch not taken", {30'd0, done, taken}, 32'b10);
        chk("R8 nmi flag sticky", 32'(nmi_blocked), 1);
        nmi_unblock = 1'b1;
        @(negedge clk);
        nmi_unblock = 1'b0;
        chk("R8 nmi flag released", 32'(nmi_blocked), 0);

        // R2: set wins over clear in the dispatch cycle
        do_reset();
        load(7'h20, 1'b1);
        req_set  = 7'h40;
        hw_vector = 8'h44;
        dispatch = 1'b1;
        @(negedge clk);
        req_set  = '0;
        dispatch = 1'b0;
        chk("R2 virtual set survives hardware clear", 32'(pending), 32'h40);
        chk("R10 vector from controller", 32'(vector), 32'h44);
        virt_vector = 8'h66;
        vctl_set = 1'b1;
        dispatch = 1'b1;
        @(negedge clk);
        vctl_set = 1'b0;
        dispatch = 1'b0;
        chk("R2 vctl set beats clear", 32'(vctl_irq), 1);
        chk("R11 virtual vector", 32'(vector), 32'h66);

        // R3: back-to-back drain of all sources
        do_reset();
        load(7'h7F, 1'b0);
        hw_vector = 8'h21;
        begin
            logic [6:0] exp_seq [7] = '{7'h7E, 7'h7C, 7'h78, 7'h70, 7'h60, 7'h00, 7'h00};
            logic       exp_tk  [7] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            dispatch = 1'b1;
            for (int s = 0; s < 7; s++) begin
                @(negedge clk);
                chk($sformatf("R3 drain pending step %0d", s), 32'(pending), 32'(exp_seq[s]));
                chk($sformatf("R3 drain taken step %0d", s), 32'(taken), 32'(exp_tk[s]));
            end
            dispatch = 1'b0;
        end

        // R12: no dispatch leaves pending untouched
        do_reset();
        load(7'h10, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R12 hold without dispatch", {24'd0, done, pending}, 32'h10);

        report();
    end
endmodule